// File: doc/BRIEF.md
# Programmable Two-Port Parallel Interface

This block sits between a host bus and two 8-bit parallel peripheral ports. The host reaches four internal registers over one shared bidirectional data bus. It uses a chip select, a two-bit register select, and separate read and write strobes. The data bus is driven by the block only while a selected read is in progress. At all other times the block leaves the bus floating, so other devices can share it.

Software sets how each port behaves by writing a mode byte to the configuration register. A port in input mode samples its external pins into its data register on every clock. When a sample brings in a new value, a per-port "fresh data" flag is raised in the read-only condition register. Reading that port's data register clears the flag. A port in output mode holds what the host last wrote into it, drives that value on its pins, and enables its pin drivers.

An access sequencer follows the host strobes through three states. ST_IDLE means no access is in progress. ST_READ means a selected read is in progress. ST_WRITE means a selected write is in progress. From any state, a valid read request moves the sequencer to ST_READ, a valid write request moves it to ST_WRITE, and anything else returns it to ST_IDLE. The transition into ST_READ from either of the other two states is the "first read cycle". Flag clearing happens only on that transition, so a read held for many cycles clears a flag once.

Top module: `pport_iface`

## Requirements
- R1: After reset, the configuration register reads 0x00, the condition register reads 0x00, and both ports are in input mode with their pin enables low.
- R2: With chip select high and a write request, the register select picks the target: 0 is port A data, 1 is port B data, 2 is the configuration register. Reads use the same decode, and 3 addresses the condition register. A write takes effect at the rising clock edge while the write request is held. Configuration bit 0 set to 1 makes port A an output, and bit 1 does the same for port B. All eight configuration bits read back as written.
- R3: The block drives the data bus only when chip select is high, the read strobe is high and the write strobe is low. Otherwise the bus floats.
- R4: A port in input mode loads its pin value into its data register at every rising clock edge. A read of that port returns the sampled value.
- R5: Condition bit 0 (port A) and bit 1 (port B) go to 1 when an input-mode port samples a value that differs from its register. Reading the port's data register clears the flag, once, at the first cycle of the read. If a new sample arrives in that same cycle, the set takes priority. Condition bits 7:2 always read 0.
- R6: The condition register is read-only. A write to register select 3 changes no register.
- R7: A host write to a port that is in input mode has no effect. The next read of that port returns the pin value.
- R8: When the read and write strobes are both high, nothing is written and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_sel | input | 1 | High selects the block |
| reg_sel | input | 2 | Register select |
| rd_strobe | input | 1 | Host read request |
| wr_strobe | input | 1 | Host write request |
| host_data | inout | 8 | Shared bidirectional data bus |
| pa_in | input | 8 | Port A pin input values |
| pa_out | output | 8 | Port A pin output values |
| pa_oe | output | 1 | Port A pin drive enable |
| pb_in | input | 8 | Port B pin input values |
| pb_out | output | 8 | Port B pin output values |
| pb_oe | output | 1 | Port B pin drive enable |

## Verification
Some properties are checked by assertions on every cycle:
- the bus drive enable stays low when the block is deselected, during writes, and when both strobes are high;
- an output-mode write to port A appears on its pins one edge later;
- configuration bit 0 moves the port A pin enable;
- an input-mode port A tracks its pins;
- a first read cycle with no new sample leaves the port A flag cleared.

Other behaviour is shown only by the bench scenarios:
- the bus actually floating, seen as the bench's own value surviving on the bus;
- the full decode sweep over every mode combination;
- input-mode writes being overridden by the pins;
- the condition register ignoring writes;
- flags being raised and cleared for each port in turn.

// File: rtl/pport_pkg.sv
package pport_pkg;

    typedef enum logic [1:0] {
        SEL_PORT_A = 2'd0,
        SEL_PORT_B = 2'd1,
        SEL_CONFIG = 2'd2,
        SEL_COND   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bus_state_e;

    localparam int unsigned NUM_PORTS = 2;

endpackage

// File: rtl/pport_bus_seq.sv
module pport_bus_seq
    import pport_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic chip_sel,
    input  logic rd_strobe,
    input  logic wr_strobe,
    output logic rd_active,
    output logic rd_first,
    output logic wr_commit
);

    bus_state_e state_q;
    bus_state_e state_d;
    logic       rd_req;
    logic       wr_req;

    assign rd_req = chip_sel && rd_strobe && !wr_strobe;
    assign wr_req = chip_sel && wr_strobe && !rd_strobe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_req)      state_d = ST_READ;
                else if (wr_req) state_d = ST_WRITE;
                else             state_d = ST_IDLE;
            end
            ST_READ: begin
                if (rd_req)      state_d = ST_READ;
                else if (wr_req) state_d = ST_WRITE;
                else             state_d = ST_IDLE;
            end
            ST_WRITE: begin
                if (rd_req)      state_d = ST_READ;
                else if (wr_req) state_d = ST_WRITE;
                else             state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_active = rd_req;
        wr_commit = wr_req;
        rd_first  = 1'b0;
        unique case (state_q)
            ST_IDLE:  rd_first = rd_req;
            ST_READ:  rd_first = 1'b0;
            ST_WRITE: rd_first = rd_req;
            default:  rd_first = 1'b0;
        endcase
    end

endmodule

// File: rtl/pport_lane.sv
module pport_lane #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_out,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd_clr,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] value,
    output logic              fresh,
    output logic [DATA_W-1:0] pin_out,
    output logic              pin_oe
);

    logic [DATA_W-1:0] value_q;
    logic              fresh_q;
    logic              new_sample;

    assign new_sample = !is_out && (pin_in != value_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (!is_out) begin
            value_q <= pin_in;
        end else if (host_wr) begin
            value_q <= host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fresh_q <= 1'b0;
        end else if (new_sample) begin
            fresh_q <= 1'b1;
        end else if (host_rd_clr) begin
            fresh_q <= 1'b0;
        end
    end

    assign value   = value_q;
    assign fresh   = fresh_q;
    assign pin_out = value_q;
    assign pin_oe  = is_out;

endmodule

// File: rtl/pport_iface.sv
module pport_iface
    import pport_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel,
    input  logic [1:0]        reg_sel,
    input  logic              rd_strobe,
    input  logic              wr_strobe,
    inout  wire  [DATA_W-1:0] host_data,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic              pa_oe,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic              pb_oe
);

    localparam int unsigned FLAG_PAD = DATA_W - NUM_PORTS;

    logic              rd_active;
    logic              rd_first;
    logic              wr_commit;
    logic              drv_en;
    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] cond_word;
    reg_sel_e          sel;

    logic [DATA_W-1:0] lane_pin_in  [NUM_PORTS];
    logic [DATA_W-1:0] lane_value   [NUM_PORTS];
    logic [DATA_W-1:0] lane_pin_out [NUM_PORTS];
    logic              lane_oe      [NUM_PORTS];
    logic              lane_fresh   [NUM_PORTS];

    assign sel = reg_sel_e'(reg_sel);

    pport_bus_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_sel  (chip_sel),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe),
        .rd_active (rd_active),
        .rd_first  (rd_first),
        .wr_commit (wr_commit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_commit && sel == SEL_CONFIG) begin
            cfg_q <= host_data;
        end
    end

    assign lane_pin_in[0] = pa_in;
    assign lane_pin_in[1] = pb_in;

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_lane
        pport_lane #(.DATA_W(DATA_W)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .is_out      (cfg_q[g]),
            .host_wr     (wr_commit && (reg_sel == 2'(g))),
            .host_wdata  (host_data),
            .host_rd_clr (rd_first && (reg_sel == 2'(g))),
            .pin_in      (lane_pin_in[g]),
            .value       (lane_value[g]),
            .fresh       (lane_fresh[g]),
            .pin_out     (lane_pin_out[g]),
            .pin_oe      (lane_oe[g])
        );
    end

    assign pa_out = lane_pin_out[0];
    assign pa_oe  = lane_oe[0];
    assign pb_out = lane_pin_out[1];
    assign pb_oe  = lane_oe[1];

    assign cond_word = {{FLAG_PAD{1'b0}}, lane_fresh[1], lane_fresh[0]};

    always_comb begin
        rd_data = '0;
        unique case (sel)
            SEL_PORT_A: rd_data = lane_value[0];
            SEL_PORT_B: rd_data = lane_value[1];
            SEL_CONFIG: rd_data = cfg_q;
            SEL_COND:   rd_data = cond_word;
            default:    rd_data = '0;
        endcase
    end

    assign drv_en    = rd_active;
    assign host_data = drv_en ? rd_data : {DATA_W{1'bz}};

endmodule

// File: rtl/pport_iface_chk.sv
module pport_iface_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_sel,
    input logic [1:0]        reg_sel,
    input logic              rd_strobe,
    input logic              wr_strobe,
    input logic [DATA_W-1:0] bus_val,
    input logic              drv_en,
    input logic              rd_first,
    input logic [DATA_W-1:0] pa_in,
    input logic [DATA_W-1:0] pa_value,
    input logic [DATA_W-1:0] pa_out,
    input logic              pa_oe,
    input logic              pa_fresh
);

    AST_FLOAT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_sel |-> !drv_en); // R3

    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && !rd_strobe) |-> !drv_en); // R3

    AST_CONFLICT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && wr_strobe) |-> !drv_en); // R8

    AST_WRITE_PORT_A: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel && wr_strobe && !rd_strobe && reg_sel == 2'd0 && pa_oe)
        |=> (pa_out == $past(bus_val))); // R2

    AST_CONFIG_SETS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel && wr_strobe && !rd_strobe && reg_sel == 2'd2)
        |=> (pa_oe == $past(bus_val[0]))); // R2

    AST_INPUT_TRACKS_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        !pa_oe |=> (pa_value == $past(pa_in))); // R4

    AST_READ_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_first && reg_sel == 2'd0 && (pa_oe || pa_in == pa_value))
        |=> !pa_fresh); // R5

endmodule

bind pport_iface pport_iface_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_sel  (chip_sel),
    .reg_sel   (reg_sel),
    .rd_strobe (rd_strobe),
    .wr_strobe (wr_strobe),
    .bus_val   (host_data),
    .drv_en    (drv_en),
    .rd_first  (rd_first),
    .pa_in     (pa_in),
    .pa_value  (lane_value[0]),
    .pa_out    (pa_out),
    .pa_oe     (pa_oe),
    .pa_fresh  (lane_fresh[0])
);

// File: tb/pport_iface_bench.sv
`timescale 1ns/1ps
module pport_iface_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_sel = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       rd_strobe = 1'b0;
    logic       wr_strobe = 1'b0;
    logic       tb_drv = 1'b0;
    logic [7:0] tb_bus = 8'h00;
    logic [7:0] pa_in = 8'h00;
    logic [7:0] pb_in = 8'h00;
    logic [7:0] pa_out;
    logic [7:0] pb_out;
    logic       pa_oe;
    logic       pb_oe;
    wire  [7:0] host_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    assign host_data = tb_drv ? tb_bus : 8'bz;

    always #2.5 clk = ~clk;

    pport_iface u_pport_iface (
        .clk       (clk),
        .rst_n     (rst_n),
        .chip_sel  (chip_sel),
        .reg_sel   (reg_sel),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe),
        .host_data (host_data),
        .pa_in     (pa_in),
        .pa_out    (pa_out),
        .pa_oe     (pa_oe),
        .pb_in     (pb_in),
        .pb_out    (pb_out),
        .pb_oe     (pb_oe)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        chip_sel = 1'b1; wr_strobe = 1'b1; reg_sel = sel; tb_drv = 1'b1; tb_bus = d;
        @(negedge clk);
        chip_sel = 1'b0; wr_strobe = 1'b0; tb_drv = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        chip_sel = 1'b1; rd_strobe = 1'b1; reg_sel = sel;
        #1 d = host_data;
        @(negedge clk);
        chip_sel = 1'b0; rd_strobe = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #500000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] da;
        logic [7:0] db;
        logic [7:0] cfg;
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R1: reset state
        bus_read(2'd2, rd); check("R1 config", rd, 8'h00);
        bus_read(2'd3, rd); check("R1 cond", rd, 8'h00);
        check("R1 oe", {6'd0, pb_oe, pa_oe}, 8'h00);

        // R2 R4 R7: sweep every mode combination and several data patterns
        pa_in = 8'h5A; pb_in = 8'hC3;
        for (int m = 0; m < 4; m++) begin
            cfg = 8'(m) | 8'(m * 36 + 8);
            bus_write(2'd2, cfg);
            bus_read(2'd2, rd); check("R2 config readback", rd, cfg);
            check("R2 oe", {6'd0, pb_oe, pa_oe}, 8'(m));
            for (int k = 0; k < 6; k++) begin
                da = 8'(k * 29 + m * 7 + 3);
                db = ~da;
                bus_write(2'd0, da);
                bus_write(2'd1, db);
                bus_read(2'd0, rd);
                if (m[0]) begin
                    check("R2 port A data", rd, da);
                    check("R2 port A pins", pa_out, da);
                end else begin
                    check("R7 port A input-mode write ignored", rd, pa_in);
                end
                bus_read(2'd1, rd);
                if (m[1]) begin
                    check("R2 port B data", rd, db);
                    check("R2 port B pins", pb_out, db);
                end else begin
                    check("R7 port B input-mode write ignored", rd, pb_in);
                end
            end
        end

        // R3: deselected read leaves the bus to the bench
        @(negedge clk);
        chip_sel = 1'b0; rd_strobe = 1'b1; reg_sel = 2'd2; tb_drv = 1'b1; tb_bus = 8'hA5;
        #1 check("R3 bus floats when deselected", host_data, 8'hA5);
        @(negedge clk);
        rd_strobe = 1'b0; tb_drv = 1'b0;

        // R4: input sampling follows the pins each cycle
        bus_write(2'd2, 8'h00);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            pa_in = 8'(k * 61 + 17); pb_in = 8'(k * 23 + 90);
            @(negedge clk);
            bus_read(2'd0, rd); check("R4 port A sample", rd, 8'(k * 61 + 17));
            bus_read(2'd1, rd); check("R4 port B sample", rd, 8'(k * 23 + 90));
        end

        // R5: condition flags
        idle(2);
        bus_read(2'd0, rd);
        bus_read(2'd1, rd);
        bus_read(2'd3, rd); check("R5 flags clear", rd, 8'h00);
        @(negedge clk); pa_in = 8'h3C;
        idle(1);
        bus_read(2'd3, rd); check("R5 flag A set", rd, 8'h01);
        bus_read(2'd0, rd); check("R5 read A data", rd, 8'h3C);
        bus_read(2'd3, rd); check("R5 flag A cleared", rd, 8'h00);
        @(negedge clk); pb_in = 8'h81;
        idle(1);
        bus_read(2'd3, rd); check("R5 flag B set", rd, 8'h02);
        @(negedge clk); pa_in = 8'h44;
        idle(1);
        bus_read(2'd3, rd); check("R5 both flags", rd, 8'h03);
        bus_read(2'd1, rd); check("R5 read B data", rd, 8'h81);
        bus_read(2'd3, rd); check("R5 only A left", rd, 8'h01);
        bus_read(2'd0, rd);

        // R6: condition register ignores writes
        bus_write(2'd2, 8'h00);
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, rd); check("R6 cond unchanged", rd, 8'h00);
        bus_read(2'd2, rd); check("R6 config unchanged", rd, 8'h00);

        // R8: both strobes high writes nothing
        bus_write(2'd2, 8'h03);
        bus_write(2'd0, 8'h12);
        @(negedge clk);
        chip_sel = 1'b1; rd_strobe = 1'b1; wr_strobe = 1'b1; reg_sel = 2'd0;
        tb_drv = 1'b1; tb_bus = 8'h99;
        #1 check("R8 no drive on conflict", host_data, 8'h99);
        @(negedge clk);
        chip_sel = 1'b0; rd_strobe = 1'b0; wr_strobe = 1'b0; tb_drv = 1'b0;
        check("R8 port A unchanged", pa_out, 8'h12);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule